// File: doc/BRIEF.md
# Capture Timer Overflow Status

One channel of an up-counting timer with an input-capture function and a read-only status word. While the count-enable input is high, the counter advances once per clock. A capture trigger copies the present count into the capture data output. A single status flag reports whether the counter wrapped between two captures.

The flag is deferred. A wrap only marks a hidden pending bit, and the visible flag changes only at the next capture: it goes to one if a wrap was pending, and to zero if none was. The flag is kept up to date only in the two capture modes, free-running capture (mode 3'b010) and capture with single count (mode 3'b110).

In single-count mode, triggers alternate between two roles. A trigger while the counter is stopped restarts it from zero. A trigger while it runs captures the count and stops it. The status word can be read as a whole or through a byte view of its low half.

Top module: `cap_ovf_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, the status read returns 16'h0000 and the capture data output is zero.
- R2: In mode 3'b010 the counter advances by one on every clock with count-enable high, and a trigger loads the count present in that cycle into the capture data output, visible on the next cycle.
- R3: A counter wrap from all ones to zero does not change the visible flag (status bit 0) until a capture occurs.
- R4: A capture sets the flag to 1 if a wrap happened since the previous capture. This includes a wrap in the same cycle as the capture, where the captured value is all ones. The rule applies in both capture modes.
- R5: A capture with no wrap since the previous capture clears the flag to 0.
- R6: In any mode other than 3'b010 and 3'b110, a trigger leaves both the capture data output and the flag unchanged.
- R7: Leaving the capture modes discards a pending wrap but keeps the visible flag. A later capture with no further wrap then clears the flag.
- R8: In mode 3'b110, a trigger while stopped restarts the count from zero without capturing. A trigger while running captures the count and stops the counter. A stopped counter does not advance.
- R9: A read with word select high returns {15 zero bits, flag}. A read with only byte select high returns the low 8 bits zero-extended to 16. With neither select high the read returns zero. Word select takes priority, and bits 15 to 1 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 3 | Operating mode; 3'b010 capture, 3'b110 capture with single count |
| cnt_en_i | input | 1 | Count enable |
| cap_trig_i | input | 1 | Capture trigger, sampled each clock |
| cap_data_o | output | CNT_W (16) | Count loaded at the last capture |
| rd_word_i | input | 1 | Select the full 16-bit status word for the read |
| rd_byte_i | input | 1 | Select the low byte of the status word for the read |
| rd_data_o | output | 16 | Status read data |

## Verification
The hardest case to reach is a wrap that lands in the same clock as a capture trigger. The trigger has to be raised exactly in the cycle where the hidden count is all ones. The bench reaches it by tracking the count in its reference model and raising the trigger in that cycle.

A second hard case is a wrap that is pending when the mode leaves the capture set. The bench lets the count wrap, switches modes briefly, returns, and then captures.

To keep wraps short, the bench builds the counter at 12 bits through its width parameter.

// File: rtl/cap_tmr_pkg.sv
package cap_tmr_pkg;
   localparam logic [2:0] MODE_CAPTURE         = 3'b010;
   localparam logic [2:0] MODE_CAPTURE_ONESHOT = 3'b110;

   function automatic logic is_capture_mode(input logic [2:0] m);
      return (m == MODE_CAPTURE) || (m == MODE_CAPTURE_ONESHOT);
   endfunction
endpackage

// File: rtl/cap_tmr_counter.sv
module cap_tmr_counter
   import cap_tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [2:0]       mode_i,
   input  logic             en_i,
   input  logic             trig_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             cap_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             oneshot, start, advance;

   always_comb begin
      oneshot = (mode_i == MODE_CAPTURE_ONESHOT);
      cap_o   = trig_i && ((mode_i == MODE_CAPTURE) || (oneshot && run_q));
      start   = trig_i && oneshot && !run_q;
      advance = en_i && (!oneshot || (run_q && !cap_o));
      wrap_o  = advance && (cnt_q == '1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else begin
         if (start)        cnt_q <= '0;
         else if (advance) cnt_q <= cnt_q + 1'b1;
         if (!oneshot)     run_q <= 1'b0;
         else if (start)   run_q <= 1'b1;
         else if (cap_o)   run_q <= 1'b0;
      end
   end

   assign cnt_o = cnt_q;

   p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
      wrap_o |=> (cnt_q == '0));
   p_stopped_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (oneshot && !run_q && !trig_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cap_tmr_ovf.sv
module cap_tmr_ovf (
   input  logic clk,
   input  logic rst,
   input  logic cap_mode_i,
   input  logic cap_i,
   input  logic wrap_i,
   output logic ovf_o
);
   logic pend_q, ovf_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         if (cap_i) ovf_q <= pend_q | wrap_i;
         if (!cap_mode_i || cap_i) pend_q <= 1'b0;
         else if (wrap_i)          pend_q <= 1'b1;
      end
   end

   assign ovf_o = ovf_q;

   p_no_immediate_r3: assert property (@(posedge clk) disable iff (rst)
      (wrap_i && !cap_i) |=> $stable(ovf_q));
   p_coincide_r4: assert property (@(posedge clk) disable iff (rst)
      (cap_i && wrap_i) |=> ovf_q);
   p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      !cap_mode_i |=> $stable(ovf_q));
   p_leave_r7: assert property (@(posedge clk) disable iff (rst)
      !cap_mode_i |=> !pend_q);
endmodule

// File: rtl/cap_tmr_rdport.sv
module cap_tmr_rdport #(
   parameter int STAT_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              ovf_i,
   input  logic              rd_word_i,
   input  logic              rd_byte_i,
   output logic [STAT_W-1:0] rd_data_o
);
   logic [STAT_W-1:0] stat_w;
   logic [STAT_W-1:0] byte_view;

   always_comb begin
      stat_w    = '0;
      stat_w[0] = ovf_i;
   end

   if (BYTE_W == STAT_W) begin : g_byte_full
      assign byte_view = stat_w;
   end else begin : g_byte_ext
      assign byte_view = {{(STAT_W-BYTE_W){1'b0}}, stat_w[BYTE_W-1:0]};
   end

   always_comb begin
      if (rd_word_i)      rd_data_o = stat_w;
      else if (rd_byte_i) rd_data_o = byte_view;
      else                rd_data_o = '0;
   end
endmodule

// File: rtl/cap_ovf_timer.sv
module cap_ovf_timer
   import cap_tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int STAT_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        mode_i,
   input  logic              cnt_en_i,
   input  logic              cap_trig_i,
   output logic [CNT_W-1:0]  cap_data_o,
   input  logic              rd_word_i,
   input  logic              rd_byte_i,
   output logic [STAT_W-1:0] rd_data_o
);
   if (CNT_W < 2)       begin : g_bad_cnt  $error("CNT_W must be at least 2");  end
   if (STAT_W < 2)      begin : g_bad_stat $error("STAT_W must be at least 2"); end
   if (BYTE_W < 1 || BYTE_W > STAT_W) begin : g_bad_byte $error("BYTE_W out of range"); end

   logic [CNT_W-1:0] cnt;
   logic             cap_ev, wrap, ovf;
   logic [CNT_W-1:0] cap_q;

   cap_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .mode_i(mode_i), .en_i(cnt_en_i), .trig_i(cap_trig_i),
      .cnt_o(cnt), .cap_o(cap_ev), .wrap_o(wrap)
   );

   cap_tmr_ovf u_ovf (
      .clk(clk), .rst(rst), .cap_mode_i(is_capture_mode(mode_i)),
      .cap_i(cap_ev), .wrap_i(wrap), .ovf_o(ovf)
   );

   cap_tmr_rdport #(.STAT_W(STAT_W), .BYTE_W(BYTE_W)) u_rd (
      .ovf_i(ovf), .rd_word_i(rd_word_i), .rd_byte_i(rd_byte_i), .rd_data_o(rd_data_o)
   );

   always_ff @(posedge clk) begin
      if (rst)         cap_q <= '0;
      else if (cap_ev) cap_q <= cnt;
   end

   assign cap_data_o = cap_q;

   p_cap_track_r2: assert property (@(posedge clk) disable iff (rst)
      cap_ev |=> (cap_data_o == $past(cnt)));
   p_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
      rd_data_o[STAT_W-1:1] == '0);
endmodule

// File: tb/cap_ovf_timer_tb_top.sv
module cap_ovf_timer_tb_top;
   localparam int TB_CNT_W = 12;
   localparam int MAX      = (1 << TB_CNT_W) - 1;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic [2:0]          mode = 3'd0;
   logic                en = 1'b0, trig = 1'b0, rd_word = 1'b1, rd_byte = 1'b0;
   logic [TB_CNT_W-1:0] cap_data;
   logic [15:0]         rd_data;

   int checks = 0, errors = 0;
   int m_cnt = 0, m_cap = 0;
   bit m_run = 0, m_pend = 0, m_ovf = 0;
   bit done = 0;

   always #4 clk = ~clk;

   cap_ovf_timer #(.CNT_W(TB_CNT_W), .STAT_W(16), .BYTE_W(8)) dut_i (
      .clk(clk), .rst(rst), .mode_i(mode), .cnt_en_i(en), .cap_trig_i(trig),
      .cap_data_o(cap_data), .rd_word_i(rd_word), .rd_byte_i(rd_byte), .rd_data_o(rd_data)
   );

   // behavioural reference model, advanced once per rising edge
   always @(posedge clk) begin
      bit capm, single, cap, start, adv, wr;
      if (rst) begin
         m_cnt = 0; m_run = 0; m_pend = 0; m_ovf = 0; m_cap = 0;
      end else begin
         single = (mode == 3'd6);
         capm   = (mode == 3'd2) || single;
         cap    = trig && ((mode == 3'd2) || (single && m_run));
         start  = trig && single && !m_run;
         adv    = en && (!single || (m_run && !cap));
         wr     = adv && (m_cnt == MAX);
         if (cap) begin m_cap = m_cnt; m_ovf = m_pend || wr; end
         if (!capm || cap) m_pend = 0; else if (wr) m_pend = 1;
         if (start) m_cnt = 0; else if (adv) m_cnt = (m_cnt + 1) % (MAX + 1);
         if (!single) m_run = 0; else if (start) m_run = 1; else if (cap) m_run = 0;
      end
   end

   function automatic int model_rd();
      if (rd_word)      return {15'd0, m_ovf};
      else if (rd_byte) return {15'd0, m_ovf};
      else              return 0;
   endfunction

   // per-cycle comparison, sampled between edges
   always @(posedge clk) begin
      #2;
      if (!rst && !done) begin
         checks++;
         if (int'(cap_data) != m_cap) begin
            errors++;
            $display("FAIL R2 cycle compare cap_data: actual %0d expected %0d", cap_data, m_cap);
         end
         checks++;
         if (int'(rd_data) != model_rd()) begin
            errors++;
            $display("FAIL R9 cycle compare rd_data: actual %0h expected %0h", rd_data, model_rd());
         end
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse();
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
   endtask

   task automatic wait_cnt(int v);
      while (m_cnt != v) @(negedge clk);
   endtask

   initial begin
      int keep;
      cyc(3);
      chk("R1", "status in reset", rd_data, 0);
      chk("R1", "cap in reset", cap_data, 0);
      rst = 1'b0;
      cyc(1);
      chk("R1", "status after reset", rd_data, 0);
      chk("R1", "cap after reset", cap_data, 0);

      // free-running capture
      mode = 3'd2; en = 1'b1;
      cyc(20);
      keep = m_cnt;
      chk("R2", "count after 20 enabled cycles", keep, 20);
      pulse();
      chk("R2", "captured count", cap_data, keep);
      chk("R5", "flag after capture without wrap", rd_data, 0);

      // wrap, flag must stay low until a capture
      wait_cnt(MAX); cyc(4);
      chk("R3", "flag after wrap before capture", rd_data, 0);
      pulse();
      chk("R4", "flag after capture following wrap", rd_data, 1);

      rd_word = 1'b0; rd_byte = 1'b1; #1;
      chk("R9", "byte read of status", rd_data, 1);
      rd_byte = 1'b0; #1;
      chk("R9", "read with no select", rd_data, 0);
      rd_byte = 1'b1; rd_word = 1'b1; #1;
      chk("R9", "word over byte priority", rd_data, 1);
      rd_byte = 1'b0;

      cyc(10);
      pulse();
      chk("R5", "flag cleared on clean capture", rd_data, 0);

      // wrap in the same cycle as the capture
      wait_cnt(MAX);
      pulse();
      chk("R4", "coincident capture value", cap_data, MAX);
      chk("R4", "coincident capture flag", rd_data, 1);

      // non-capture mode ignores triggers
      mode = 3'd0;
      cyc(5);
      pulse();
      chk("R6", "cap unchanged in other mode", cap_data, MAX);
      chk("R6", "flag unchanged in other mode", rd_data, 1);

      // pending wrap discarded when leaving capture modes
      mode = 3'd2;
      cyc(5);
      pulse();
      chk("R5", "clean capture before R7 test", rd_data, 0);
      wait_cnt(MAX); cyc(3);
      mode = 3'd3;
      cyc(2);
      chk("R7", "flag held while out of capture modes", rd_data, 0);
      mode = 3'd2;
      cyc(5);
      pulse();
      chk("R7", "pending wrap discarded", rd_data, 0);
      wait_cnt(MAX); cyc(2);
      pulse();
      chk("R4", "flag set before R7 keep test", rd_data, 1);
      wait_cnt(MAX); cyc(2);
      mode = 3'd1;
      cyc(3);
      chk("R7", "visible flag kept after leaving", rd_data, 1);
      mode = 3'd2;
      cyc(4);
      pulse();
      chk("R7", "capture after return clears flag", rd_data, 0);

      // single-count mode
      keep = int'(cap_data);
      mode = 3'd6;
      cyc(5);
      pulse();
      chk("R8", "start trigger does not capture", cap_data, keep);
      cyc(30);
      pulse();
      chk("R8", "interval measured from zero", cap_data, 30);
      chk("R5", "single-count clean flag", rd_data, 0);
      cyc(40);
      chk("R8", "stopped counter holds", m_cnt, 30);
      pulse();
      cyc(12);
      pulse();
      chk("R8", "restart from zero", cap_data, 12);
      pulse();
      cyc(MAX + 5);
      pulse();
      chk("R4", "single-count wrap capture value", cap_data, 4);
      chk("R4", "single-count wrap flag", rd_data, 1);

      cyc(2);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule